// File: doc/BRIEF.md
# Divided Trigger-Clock Trigger Synchronizer

This block lets several devices whose sample clocks are already phase-aligned act on one shared trigger in exactly the same sample clock cycle. Handing a trigger from a slow reference domain to the sample domain through a plain pair of flip-flops can go metastable, and two devices may then resolve it one cycle apart. This block avoids that. It divides the sample clock down to a slow trigger clock and only launches onto, and captures from, the shared trigger line on chosen phases of that slow clock. No decision is ever taken close to a line transition. The scheme does not rely on any relation between the sample clock and a reference clock.

Every device carries one copy. A common alignment input restarts each divider, so all trigger clocks run in phase. The master device turns a local request into a pulse on the shared line. It launches the pulse at the next falling phase of the trigger clock and holds it for one full trigger-clock period. Every device, master included, samples the line at the rising phase, which falls in the middle of that window. A fixed number of sample cycles later, each device raises a one-cycle aligned trigger that marks the start of acquisition or generation.

Top module: `trig_align_sync`

## Requirements
- R1: After reset, `line_out` and `trig_out` are low.
- R2: Define c0 as the first cycle after a clock edge at which `align` is sampled high, with `align` low in c0. The trigger-clock rising phase is then the cycles c0, c0+DIV, c0+2·DIV and so on. The falling phase is the cycles c0+DIV/2, c0+DIV/2+DIV and so on.
- R3: A request sampled high at the end of cycle ck, while the launcher is idle, starts the drive. `line_out` first goes high in the cycle after the first falling-phase cycle that is later than ck. With DIV=8, a request in c3 gives a rise in c5, and a request in c4 gives a rise in c13.
- R4: Once launched, `line_out` stays high for exactly DIV cycles.
- R5: `line_in` is looked at only in rising-phase cycles. A high level confined to other cycles has no effect on `trig_out`.
- R6: When a rising-phase cycle r sees `line_in` high after the previous rising-phase sample was low, `trig_out` is high for exactly the one cycle r+DELAY.
- R7: A request arriving while an earlier request is pending (from acceptance until its aligned trigger has been issued and the drive has ended) is ignored. It produces no second launch and no second trigger.
- R8: Devices that share `align` and the line raise `trig_out` in the same cycle, even when their dividers ran out of phase before the alignment.
- R9: Once the earlier trigger has been issued and the drive window has closed, a new request is accepted again.
- R10: A line held high across several rising-phase cycles gives only one aligned trigger, taken at the first such sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| align | input | 1 | Shared divider restart, sampled on clk |
| trig_req | input | 1 | Local trigger request (used on the master) |
| line_in | input | 1 | Level seen on the shared trigger line |
| line_out | output | 1 | Drive toward the shared trigger line |
| trig_out | output | 1 | One-cycle aligned trigger |

## Verification
The bench builds two copies with DIV=8 and DELAY=3, a master and a slave whose drives are ORed onto one line. The slave leaves reset three cycles later, so the two dividers start out of phase. A ratio of 8 keeps the falling-phase boundary (a request in c3 against one in c4) and the mid-window sampling point a few cycles apart, so each can be told apart. A delay of 3 shorter than the half period makes the aligned trigger land while the line is still being driven, which exercises the pending-until-issued handling. An extra bench-driven term on the line lets it show pulses between sampling phases and a long held level.

// File: rtl/tas_pkg.sv
package tas_pkg;

    typedef enum logic [1:0] {
        L_IDLE      = 2'd0,
        L_WAIT_FALL = 2'd1,
        L_DRIVE     = 2'd2,
        L_WAIT_DONE = 2'd3
    } launch_state_e;

    typedef struct packed {
        launch_state_e state;
        logic          done_seen;
    } launch_regs_t;

endpackage

// File: rtl/tas_divider.sv
module tas_divider #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_regs_t;

    div_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (align) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == CW'(DIV - 1)) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rise_stb = (r_q.cnt == '0) && !align;
    assign fall_stb = (r_q.cnt == CW'(HALF)) && !align;

endmodule

// File: rtl/tas_launch.sv
module tas_launch
    import tas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_req,
    input  logic fall_stb,
    input  logic issued,
    output logic drive
);
    launch_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            L_IDLE: begin
                r_d.done_seen = 1'b0;
                if (trig_req) begin
                    r_d.state = L_WAIT_FALL;
                end
            end
            L_WAIT_FALL: begin
                if (fall_stb) begin
                    r_d.state = L_DRIVE;
                end
            end
            L_DRIVE: begin
                if (issued) begin
                    r_d.done_seen = 1'b1;
                end
                if (fall_stb) begin
                    r_d.state = (r_q.done_seen || issued) ? L_IDLE : L_WAIT_DONE;
                end
            end
            L_WAIT_DONE: begin
                if (issued) begin
                    r_d.state = L_IDLE;
                end
            end
            default: r_d.state = L_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: L_IDLE, done_seen: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign drive = (r_q.state == L_DRIVE);

endmodule

// File: rtl/tas_capture.sv
module tas_capture #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_stb,
    input  logic line_in,
    output logic fire
);
    localparam int DW = (DELAY > 1) ? $clog2(DELAY + 1) : 1;

    typedef struct packed {
        logic          prev;
        logic          armed;
        logic [DW-1:0] dly;
        logic          fire;
    } cap_regs_t;

    cap_regs_t r_d, r_q;
    logic      hit;

    assign hit = rise_stb && line_in && !r_q.prev && !r_q.armed;

    generate
        if (DELAY <= 1) begin : g_direct
            always_comb begin
                r_d       = r_q;
                r_d.fire  = hit;
                r_d.armed = 1'b0;
                r_d.dly   = '0;
                if (rise_stb) begin
                    r_d.prev = line_in;
                end
            end
        end else begin : g_count
            always_comb begin
                r_d      = r_q;
                r_d.fire = 1'b0;
                if (rise_stb) begin
                    r_d.prev = line_in;
                end
                if (r_q.armed) begin
                    r_d.dly = r_q.dly - DW'(1);
                    if (r_q.dly == DW'(1)) begin
                        r_d.fire  = 1'b1;
                        r_d.armed = 1'b0;
                    end
                end
                if (hit) begin
                    r_d.armed = 1'b1;
                    r_d.dly   = DW'(DELAY - 1);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fire = r_q.fire;

endmodule

// File: rtl/trig_align_sync.sv
module trig_align_sync #(
    parameter int DIV   = 8,
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic align,
    input  logic trig_req,
    input  logic line_in,
    output logic line_out,
    output logic trig_out
);
    logic rise_stb;
    logic fall_stb;
    logic fire;

    tas_divider #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .align    (align),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    tas_launch u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_req (trig_req),
        .fall_stb (fall_stb),
        .issued   (fire),
        .drive    (line_out)
    );

    tas_capture #(.DELAY(DELAY)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_stb (rise_stb),
        .line_in  (line_in),
        .fire     (fire)
    );

    assign trig_out = fire;

endmodule

// File: rtl/tas_chk.sv
module tas_chk #(
    parameter int DIV = 8
) (
    input logic clk,
    input logic rst_n,
    input logic rise_stb,
    input logic fall_stb,
    input logic line_out,
    input logic trig_out
);
    localparam int HALF = DIV / 2;

    int unsigned hi_cnt;
    int unsigned since_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt     <= 0;
            since_rise <= 0;
        end else begin
            hi_cnt     <= line_out ? hi_cnt + 1 : 0;
            since_rise <= rise_stb ? 1 : since_rise + 1;
        end
    end

    // R2: falling phase lies half a period after the rising phase
    p_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> since_rise == HALF);

    // R3: the line is only ever launched right after a falling phase
    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_out) |-> $past(fall_stb));

    // R4: drive window lasts one full trigger-clock period
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_out) |-> hi_cnt == DIV);

    // R6: aligned trigger is a single cycle wide
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

endmodule

bind trig_align_sync tas_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .line_out (line_out),
    .trig_out (trig_out)
);

// File: tb/trig_align_sync_tb.sv
`timescale 1ns/1ps
module trig_align_sync_tb;
    localparam int DIV   = 8;
    localparam int DELAY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_s_n = 1'b0;
    logic align = 1'b0;
    logic req = 1'b0;
    logic ext_line = 1'b0;
    logic m_line, s_line, m_trig, s_trig;
    logic shared;

    int pc = 0;
    int base = 0;
    int n_chk = 0;
    int n_fail = 0;

    int m_trig_cnt, m_trig_at, s_trig_cnt, s_trig_at;
    int rise_cnt, rise_at, hi_run, hi_len;
    logic m_line_prev;

    assign shared = m_line | s_line | ext_line;

    always #10 clk = ~clk;

    trig_align_sync #(.DIV(DIV), .DELAY(DELAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .align(align), .trig_req(req),
        .line_in(shared), .line_out(m_line), .trig_out(m_trig)
    );

    trig_align_sync #(.DIV(DIV), .DELAY(DELAY)) u_slave (
        .clk(clk), .rst_n(rst_s_n), .align(align), .trig_req(1'b0),
        .line_in(shared), .line_out(s_line), .trig_out(s_trig)
    );

    always @(posedge clk) pc <= pc + 1;

    task automatic clear_mon();
        m_trig_cnt = 0; m_trig_at = -1;
        s_trig_cnt = 0; s_trig_at = -1;
        rise_cnt = 0; rise_at = -1;
        hi_run = 0; hi_len = -1;
        m_line_prev = 1'b0;
    endtask

    always @(negedge clk) begin
        if (m_trig) begin m_trig_cnt++; m_trig_at = pc - base; end
        if (s_trig) begin s_trig_cnt++; s_trig_at = pc - base; end
        if (m_line && !m_line_prev) begin
            if (rise_cnt == 0) rise_at = pc - base;
            rise_cnt++;
        end
        if (m_line) hi_run++;
        else if (m_line_prev) begin hi_len = hi_run; hi_run = 0; end
        m_line_prev = m_line;
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_align();
        @(negedge clk);
        align = 1'b1;
        @(posedge clk);
        #1;
        align = 1'b0;
        base = pc;
        clear_mon();
    endtask

    task automatic goto(int k);
        while (pc - base != k) @(negedge clk);
    endtask

    task automatic pulse_req(int k);
        goto(k); req = 1'b1;
        goto(k + 1); req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 line_out after reset", int'(m_line), 0);
        check("R1 trig_out after reset", int'(m_trig), 0);
    endtask

    task automatic t_basic();
        do_align();
        pulse_req(1);
        goto(40);
        check("R3 launch cycle for request in c1", rise_at, 5);
        check("R4 drive length", hi_len, DIV);
        check("R6 master trigger cycle", m_trig_at, 11);
        check("R6 master trigger count", m_trig_cnt, 1);
        check("R8 slave trigger cycle", s_trig_at, 11);
        check("R8 slave trigger count", s_trig_cnt, 1);
    endtask

    task automatic t_edge_c3();
        do_align();
        pulse_req(3);
        goto(40);
        check("R3 launch cycle for request in c3", rise_at, 5);
        check("R6 trigger for request in c3", m_trig_at, 11);
    endtask

    task automatic t_edge_c4();
        do_align();
        pulse_req(4);
        goto(40);
        check("R3 launch cycle for request in c4", rise_at, 13);
        check("R6 trigger for request in c4", m_trig_at, 19);
        check("R8 slave for request in c4", s_trig_at, 19);
    endtask

    task automatic t_busy();
        do_align();
        pulse_req(1);
        pulse_req(6);
        pulse_req(10);
        goto(48);
        check("R7 launches while pending", rise_cnt, 1);
        check("R7 triggers while pending", m_trig_cnt, 1);
    endtask

    task automatic t_rearm();
        do_align();
        pulse_req(1);
        pulse_req(13);
        goto(44);
        check("R9 second launch count", rise_cnt, 2);
        check("R9 second trigger count", m_trig_cnt, 2);
        check("R9 last trigger cycle", m_trig_at, 27);
    endtask

    task automatic t_offphase();
        do_align();
        goto(1); ext_line = 1'b1;
        goto(7); ext_line = 1'b0;
        goto(9); ext_line = 1'b1;
        goto(15); ext_line = 1'b0;
        goto(30);
        check("R5 master ignores off-phase line", m_trig_cnt, 0);
        check("R5 slave ignores off-phase line", s_trig_cnt, 0);
    endtask

    task automatic t_held();
        do_align();
        goto(1); ext_line = 1'b1;
        goto(21); ext_line = 1'b0;
        goto(40);
        check("R10 one trigger for held line", m_trig_cnt, 1);
        check("R10 trigger at first sampling", m_trig_at, 11);
        check("R10 slave same cycle", s_trig_at, 11);
    endtask

    initial begin : watchdog
        #(20 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_s_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_edge_c3();
        t_edge_c4();
        t_busy();
        t_rearm();
        t_offphase();
        t_held();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule